// File: doc/BRIEF.md
# Serial Port Register Bank with Threshold Interrupt

This block is the processor-facing side of a byte-oriented serial port. It sits on a simple word-addressed register bus and holds a transmit queue and a receive queue, each 64 bytes deep. It also holds a control word, a status view, a pair of interrupt thresholds and a baud divisor word. The bit-serial transmitter, the receiver and the baud tick generator live outside the block. They connect through plain handshake pins. The transmitter takes bytes from the head of the transmit queue. The receiver pushes bytes into the receive queue and signals parity and framing faults as one-cycle pulses.

Software writes bytes to the write-queue offset and reads received bytes from the read-queue offset. Three fault conditions are latched: parity, framing, and a write to a full transmit queue. They stay set until software raises the error-clear control bit and later lowers it again. The two queue-reset control bits behave the same way, as held levels. A single interrupt line combines a receive request and a transmit request. The receive request rises when enough bytes are waiting. The transmit request rises when the transmit queue has drained to a low-water level.

Top module: `uart_regbank`

## Requirements
- R1: After reset the control, threshold and baud words read 0, the status word reads 0x0050_0000 (receive empty bit 20 and transmit empty bit 22 set), irq is 0 and tx_valid is 0.
- R2: Word offsets are 0x08 control, 0x10 thresholds and 0x14 baud. Control keeps only bits 12, 13, 15, 16 to 24, 27 and 28. Thresholds keep bits 15:0. Baud keeps bits 24:0. Every other bit reads 0. Offsets 0x18 and 0x1C, and any address with bits 1:0 not zero, read 0 and ignore writes. frame_cfg mirrors control bits 21:16 and baud_word mirrors the baud word.
- R3: Bytes written to offset 0x00 (bits 7:0) are presented on tx_data in write order, one per cycle in which tx_take is high while tx_valid is high. Status bit 21 reads 1 when 64 bytes are queued and bit 22 reads 1 when none are.
- R4: A write to offset 0x00 while the transmit queue is full drops the byte and sets status bit 18, which stays set.
- R5: Bytes pushed with rx_push while rx_en is set are returned in order by reads of offset 0x04, in bits 7:0 with bits 31:8 zero. Each such read removes one byte. Status bit 20 is 1 exactly when the receive queue is empty.
- R6: A read of offset 0x04 with the receive queue empty returns 0 and removes nothing, so a byte pushed later is the next one read.
- R7: A pulse on rx_par_err sets status bit 16 and a pulse on rx_frm_err sets status bit 17. Both stay set.
- R8: While control bit 24 is 1, status bits 18:16 read 0 and new faults do not set them. After bit 24 returns to 0 they stay 0 until a new fault occurs.
- R9: While control bit 22 (transmit) or bit 23 (receive) is 1, that queue is emptied and stays empty, and bytes offered to it are discarded.
- R10: With control bit 27 set, irq is 1 when the receive queue holds at least the count in threshold bits 7:0.
- R11: With control bit 28 set, irq is 1 when the transmit queue holds at most the count in threshold bits 15:8.
- R12: Status bit 25 follows the tx_busy input, separately from the transmit empty bit 22.
- R13: Control bit 12 (tx_en) gates tx_valid, so queued bytes wait while it is 0. Control bit 13 (rx_en) gates rx_push, so pushes while it is 0 are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, pops the receive queue at offset 0x04 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| irq | output | 1 | Combined threshold interrupt |
| tx_en | output | 1 | Transmit engine enable (control bit 12) |
| rx_en | output | 1 | Receive engine enable (control bit 13) |
| two_wire | output | 1 | No-flow-control mode (control bit 15) |
| frame_cfg | output | 6 | Stop, parity and length settings (control bits 21:16) |
| baud_word | output | 25 | Baud divisor and clock select word |
| tx_valid | output | 1 | A queued byte is offered to the transmitter |
| tx_data | output | 8 | Byte at the head of the transmit queue |
| tx_take | input | 1 | Transmitter accepts the offered byte |
| tx_busy | input | 1 | Transmit shifter is active |
| rx_push | input | 1 | Receiver delivers a byte |
| rx_data | input | 8 | Received byte |
| rx_par_err | input | 1 | Parity fault pulse |
| rx_frm_err | input | 1 | Framing fault pulse |

## Verification
Register readback is driven with all-ones and with mixed patterns, to separate the kept bits from the masked bits. Unmapped and misaligned addresses are also written, to show that nothing leaks. Each queue is run with a few distinct bytes to show ordering, and then filled to exactly 64 with byte values equal to their index. The first value after drain tells a dropped overflow byte apart from an overwritten one. The fault flags are driven with pulses both during and after the clear level, which separates a one-shot clear from a held clear. Each interrupt threshold is approached from both sides, so an off-by-one in the comparison shows up.

// File: rtl/uart_rb_pkg.sv
// Package: register offsets, bit positions and masks of the serial port
// register bank. Offsets are word indices (byte address / 4).
package uart_rb_pkg;

    localparam int BUS_W = 32;

    // word indices of the register map
    localparam int WIX_TXQ  = 0;
    localparam int WIX_RXQ  = 1;
    localparam int WIX_CTRL = 2;
    localparam int WIX_STAT = 3;
    localparam int WIX_THR  = 4;
    localparam int WIX_BAUD = 5;

    // control word bit positions
    localparam int CB_TX_EN   = 12;
    localparam int CB_RX_EN   = 13;
    localparam int CB_TWO_W   = 15;
    localparam int CB_FRM_LO  = 16;
    localparam int CB_FRM_HI  = 21;
    localparam int CB_TX_RST  = 22;
    localparam int CB_RX_RST  = 23;
    localparam int CB_ERR_CLR = 24;
    localparam int CB_RX_IE   = 27;
    localparam int CB_TX_IE   = 28;

    // status word bit positions
    localparam int SB_PAR   = 16;
    localparam int SB_FRM   = 17;
    localparam int SB_WOVF  = 18;
    localparam int SB_RXE   = 20;
    localparam int SB_TXF   = 21;
    localparam int SB_TXE   = 22;
    localparam int SB_BUSY  = 25;

    // writable bits of each register
    localparam logic [BUS_W-1:0] CTRL_KEEP = 32'h19FF_B000;
    localparam logic [BUS_W-1:0] THR_KEEP  = 32'h0000_FFFF;
    localparam int               BAUD_W    = 25;

    // index of each sticky fault flag in the flag vector
    typedef enum logic [1:0] {
        FLT_PAR  = 2'd0,
        FLT_FRM  = 2'd1,
        FLT_WOVF = 2'd2
    } fault_idx_e;

endpackage

// File: rtl/uart_rb_fifo.sv
// Module: uart_rb_fifo
// Circular byte queue with a held synchronous clear. Push is dropped when
// full, pop is ignored when empty, and clear dominates both. Assumes one
// push and one pop at most per cycle. The head output is meaningful only
// when not empty.
module uart_rb_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 64
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clr,
    input  logic                            push,
    input  logic [WIDTH-1:0]                push_data,
    input  logic                            pop,
    output logic [WIDTH-1:0]                head,
    output logic [$clog2(DEPTH+1)-1:0]      count,
    output logic                            empty,
    output logic                            full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    // Purpose: qualify requests against occupancy and the held clear.
    always_comb begin
        do_push = push && !full && !clr;
        do_pop  = pop && !empty && !clr;
    end

    // Purpose: store pushed data; storage needs no reset.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Purpose: advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Purpose: export occupancy flags and the head entry.
    always_comb begin
        count = cnt_q;
        empty = (cnt_q == '0);
        full  = (cnt_q == FULL_CNT);
        head  = mem[rd_ptr];
    end
endmodule

// File: rtl/uart_rb_faults.sv
// Module: uart_rb_faults
// Sticky fault flags. Any set pulse latches its flag. A held clear level
// forces all flags to 0 and masks new set pulses for as long as it is held.
module uart_rb_faults #(
    parameter int NFLT = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_hold,
    input  logic [NFLT-1:0] set_pulse,
    output logic [NFLT-1:0] flags
);
    logic [NFLT-1:0] flags_q;

    // Purpose: one sticky flop per fault, generated per index.
    for (genvar g = 0; g < NFLT; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n || clr_hold) begin
                flags_q[g] <= 1'b0;
            end else if (set_pulse[g]) begin
                flags_q[g] <= 1'b1;
            end
        end
    end

    assign flags = flags_q;
endmodule

// File: rtl/uart_rb_irq.sv
// Module: uart_rb_irq
// Combines the receive and transmit level requests into one line. The
// receive request compares count >= threshold and the transmit request
// compares count <= threshold. Both are purely combinational and assume
// the counts and thresholds are stable registers.
module uart_rb_irq #(
    parameter int CNT_W = 7,
    parameter int THR_W = 8
) (
    input  logic             rx_ie,
    input  logic             tx_ie,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [THR_W-1:0] rx_thr,
    input  logic [THR_W-1:0] tx_thr,
    output logic             irq
);
    localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

    logic rx_hit, tx_hit;

    // Purpose: widen both operands and evaluate each level request.
    always_comb begin
        rx_hit = rx_ie && (CMP_W'(rx_cnt) >= CMP_W'(rx_thr));
        tx_hit = tx_ie && (CMP_W'(tx_cnt) <= CMP_W'(tx_thr));
        irq    = rx_hit || tx_hit;
    end
endmodule

// File: rtl/uart_regbank.sv
// Module: uart_regbank
// Register front end of a serial port: decodes word accesses, owns the two
// byte queues, the control, threshold and baud words, the sticky faults and
// the interrupt line. Assumes at most one bus access per cycle, and that the
// serial engines honour tx_valid/tx_take and deliver rx_push as one-cycle
// strobes. Read data is combinational from bus_addr.
module uart_regbank
    import uart_rb_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              tx_en,
    output logic              rx_en,
    output logic              two_wire,
    output logic [5:0]        frame_cfg,
    output logic [24:0]       baud_word,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_take,
    input  logic              tx_busy,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_par_err,
    input  logic              rx_frm_err
);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam int WIX_W = ADDR_W - 2;
    localparam int THR_W = 8;
    localparam int NFLT  = 3;

    logic [BUS_W-1:0]  ctrl_q;
    logic [2*THR_W-1:0] thr_q;
    logic [BAUD_W-1:0] baud_q;

    logic              aligned;
    logic [WIX_W-1:0]  wix;
    logic              wr_txq, wr_ctrl, wr_thr, wr_baud, rd_rxq;

    logic [DATA_W-1:0] tx_head, rx_head;
    logic [CNT_W-1:0]  tx_count, rx_count;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic              tx_pop, rx_in;

    logic [NFLT-1:0]   fault_set;
    logic [NFLT-1:0]   err_flags;
    logic [BUS_W-1:0]  status;

    // Purpose: decode the word index and the per-register strobes.
    always_comb begin
        aligned = (bus_addr[1:0] == 2'b00);
        wix     = bus_addr[ADDR_W-1:2];
        wr_txq  = bus_wr && aligned && (wix == WIX_W'(WIX_TXQ));
        wr_ctrl = bus_wr && aligned && (wix == WIX_W'(WIX_CTRL));
        wr_thr  = bus_wr && aligned && (wix == WIX_W'(WIX_THR));
        wr_baud = bus_wr && aligned && (wix == WIX_W'(WIX_BAUD));
        rd_rxq  = bus_rd && aligned && (wix == WIX_W'(WIX_RXQ));
    end

    // Purpose: hold the writable configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            thr_q  <= '0;
            baud_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_KEEP;
            if (wr_thr)  thr_q  <= bus_wdata[2*THR_W-1:0];
            if (wr_baud) baud_q <= bus_wdata[BAUD_W-1:0];
        end
    end

    // Purpose: engine-side handshakes gated by the enables.
    always_comb begin
        tx_valid = ctrl_q[CB_TX_EN] && !tx_empty;
        tx_pop   = tx_take && tx_valid;
        rx_in    = rx_push && ctrl_q[CB_RX_EN];
        tx_data  = tx_head;
    end

    uart_rb_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ctrl_q[CB_TX_RST]),
        .push      (wr_txq),
        .push_data (bus_wdata[DATA_W-1:0]),
        .pop       (tx_pop),
        .head      (tx_head),
        .count     (tx_count),
        .empty     (tx_empty),
        .full      (tx_full)
    );

    uart_rb_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ctrl_q[CB_RX_RST]),
        .push      (rx_in),
        .push_data (rx_data),
        .pop       (rd_rxq),
        .head      (rx_head),
        .count     (rx_count),
        .empty     (rx_empty),
        .full      (rx_full)
    );

    // Purpose: gather fault set pulses in flag-vector order.
    always_comb begin
        fault_set            = '0;
        fault_set[FLT_PAR]   = rx_par_err;
        fault_set[FLT_FRM]   = rx_frm_err;
        fault_set[FLT_WOVF]  = wr_txq && tx_full;
    end

    uart_rb_faults #(.NFLT(NFLT)) u_faults (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_hold  (ctrl_q[CB_ERR_CLR]),
        .set_pulse (fault_set),
        .flags     (err_flags)
    );

    uart_rb_irq #(.CNT_W(CNT_W), .THR_W(THR_W)) u_irq (
        .rx_ie  (ctrl_q[CB_RX_IE]),
        .tx_ie  (ctrl_q[CB_TX_IE]),
        .rx_cnt (rx_count),
        .tx_cnt (tx_count),
        .rx_thr (thr_q[THR_W-1:0]),
        .tx_thr (thr_q[2*THR_W-1:THR_W]),
        .irq    (irq)
    );

    // Purpose: assemble the status word from flags and queue state.
    always_comb begin
        status           = '0;
        status[SB_PAR]   = err_flags[FLT_PAR];
        status[SB_FRM]   = err_flags[FLT_FRM];
        status[SB_WOVF]  = err_flags[FLT_WOVF];
        status[SB_RXE]   = rx_empty;
        status[SB_TXF]   = tx_full;
        status[SB_TXE]   = tx_empty;
        status[SB_BUSY]  = tx_busy;
    end

    // Purpose: select read data for the addressed word.
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (wix)
                WIX_W'(WIX_RXQ):  bus_rdata = rx_empty ? '0
                                  : {{(BUS_W-DATA_W){1'b0}}, rx_head};
                WIX_W'(WIX_CTRL): bus_rdata = ctrl_q;
                WIX_W'(WIX_STAT): bus_rdata = status;
                WIX_W'(WIX_THR):  bus_rdata = {{(BUS_W-2*THR_W){1'b0}}, thr_q};
                WIX_W'(WIX_BAUD): bus_rdata = {{(BUS_W-BAUD_W){1'b0}}, baud_q};
                default:          bus_rdata = '0;
            endcase
        end
    end

    // Purpose: drive the engine configuration outputs.
    always_comb begin
        tx_en     = ctrl_q[CB_TX_EN];
        rx_en     = ctrl_q[CB_RX_EN];
        two_wire  = ctrl_q[CB_TWO_W];
        frame_cfg = ctrl_q[CB_FRM_HI:CB_FRM_LO];
        baud_word = baud_q;
    end

    // the receive full flag is implied by the dropped push; keep it named
    logic rx_full_unused;
    assign rx_full_unused = rx_full;
endmodule

// File: rtl/uart_regbank_chk.sv
// Module: uart_regbank_chk
// Property checker for uart_regbank, attached by bind below. It observes
// ports and internal state across cycles and drives nothing.
module uart_regbank_chk #(
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [31:0]       bus_rdata,
    input logic              irq,
    input logic [31:0]       ctrl_q,
    input logic [2:0]        err_flags,
    input logic              tx_full,
    input logic              tx_empty,
    input logic              rx_empty,
    input logic [CNT_W-1:0]  rx_count
);
    logic at_txq, at_rxq;

    // Purpose: aligned address match for the two queue offsets.
    always_comb begin
        at_txq = (bus_addr == ADDR_W'(0));
        at_rxq = (bus_addr == ADDR_W'(4));
    end

    assert_wovf_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_txq && tx_full && !ctrl_q[24]) |=> err_flags[2]);

    assert_clear_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[24] |=> (err_flags == 3'b000));

    assert_rx_reset_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[23] |=> rx_empty);

    assert_tx_reset_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[22] |=> tx_empty);

    assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && at_rxq && rx_empty) |-> (bus_rdata == 32'h0));

    assert_rx_gated_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[13] && !ctrl_q[23] && !(bus_rd && at_rxq)) |=> $stable(rx_count));

    assert_tx_low_water_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[28] && tx_empty) |-> irq);
endmodule

bind uart_regbank uart_regbank_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .ctrl_q    (ctrl_q),
    .err_flags (err_flags),
    .tx_full   (tx_full),
    .tx_empty  (tx_empty),
    .rx_empty  (rx_empty),
    .rx_count  (rx_count)
);

// File: tb/tb_uart_regbank.sv
`timescale 1ns/1ps
module tb_uart_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, tx_en, rx_en, two_wire;
    logic [5:0]  frame_cfg;
    logic [24:0] baud_word;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_take = 1'b0;
    logic        tx_busy = 1'b0;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_par_err = 1'b0;
    logic        rx_frm_err = 1'b0;

    int checks = 0;
    int fails  = 0;
    logic [31:0] v;

    uart_regbank dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .tx_en(tx_en), .rx_en(rx_en), .two_wire(two_wire),
        .frame_cfg(frame_cfg), .baud_word(baud_word), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_take(tx_take), .tx_busy(tx_busy),
        .rx_push(rx_push), .rx_data(rx_data), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err)
    );

    always #5 clk = ~clk;

    // {address, write data, expected readback}
    localparam int NV = 8;
    localparam logic [68:0] VEC [NV] = '{
        {5'h08, 32'hFFFF_FFFF, 32'h19FF_B000},
        {5'h08, 32'h00A5_3000, 32'h00A5_3000},
        {5'h10, 32'hFFFF_FFFF, 32'h0000_FFFF},
        {5'h10, 32'h1234_0201, 32'h0000_0201},
        {5'h14, 32'hFFFF_FFFF, 32'h01FF_FFFF},
        {5'h14, 32'h8012_3456, 32'h0012_3456},
        {5'h18, 32'hDEAD_BEEF, 32'h0000_0000},
        {5'h1C, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0; #1;
    endtask

    task automatic rd(input logic [4:0] a);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 v = bus_rdata;
        @(negedge clk); bus_rd = 1'b0; #1;
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk); rx_data = d; rx_push = 1'b1;
        @(negedge clk); rx_push = 1'b0; #1;
    endtask

    task automatic take();
        @(negedge clk); tx_take = 1'b1;
        @(negedge clk); tx_take = 1'b0; #1;
    endtask

    initial begin : watchdog
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        int bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        rd(5'h08); chk("R1 ctrl", v, 32'h0);
        rd(5'h0C); chk("R1 status", v, 32'h0050_0000);
        rd(5'h10); chk("R1 thr", v, 32'h0);
        rd(5'h14); chk("R1 baud", v, 32'h0);
        chk("R1 irq/tx_valid", {30'h0, irq, tx_valid}, 32'h0);

        // R2 register table
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][68:64], VEC[i][63:32]);
            rd(VEC[i][68:64]);
            chk("R2 readback", v, VEC[i][31:0]);
        end
        wr(5'h08, 32'h00A5_3000);
        chk("R2 frame_cfg", {26'h0, frame_cfg}, 32'h25);
        chk("R2 baud_word", {7'h0, baud_word}, 32'h0012_3456);
        wr(5'h08, 32'h0);
        wr(5'h0A, 32'hFFFF_FFFF);
        rd(5'h08); chk("R2 misaligned write ignored", v, 32'h0);
        wr(5'h10, 32'h0);

        // R3 / R13 transmit ordering and enable gate
        wr(5'h00, 32'h11); wr(5'h00, 32'h22); wr(5'h00, 32'hFFFF_FF33);
        chk("R13 tx held while disabled", {31'h0, tx_valid}, 32'h0);
        wr(5'h08, 32'h0000_1000);
        chk("R3 first byte", {23'h0, tx_valid, tx_data}, 32'h111);
        take(); chk("R3 second byte", {24'h0, tx_data}, 32'h22);
        take(); chk("R3 third byte", {24'h0, tx_data}, 32'h33);
        take(); chk("R3 drained", {31'h0, tx_valid}, 32'h0);
        rd(5'h0C); chk("R3 empty status", v & 32'h0060_0000, 32'h0040_0000);

        // R3 / R4 fill to capacity and overflow
        wr(5'h08, 32'h0);
        for (int i = 0; i < 64; i++) wr(5'h00, 32'(i));
        rd(5'h0C); chk("R3 full flag, no fault", v & 32'h0064_0000, 32'h0020_0000);
        wr(5'h00, 32'hEE);
        rd(5'h0C); chk("R4 overflow fault", v & 32'h0004_0000, 32'h0004_0000);
        wr(5'h08, 32'h0000_1000);
        bad = 0;
        for (int i = 0; i < 64; i++) begin
            if (!tx_valid || tx_data != 8'(i)) bad++;
            take();
        end
        chk("R4 64 bytes in order, overflow byte dropped", 32'(bad), 32'h0);
        chk("R4 nothing after 64", {31'h0, tx_valid}, 32'h0);
        rd(5'h0C); chk("R4 fault sticky", v & 32'h0004_0000, 32'h0004_0000);

        // R8 / R7 held clear and sticky faults
        wr(5'h08, 32'h0100_0000);
        rd(5'h0C); chk("R8 cleared", v & 32'h0007_0000, 32'h0);
        @(negedge clk); rx_frm_err = 1'b1; @(negedge clk); rx_frm_err = 1'b0;
        rd(5'h0C); chk("R8 masked while held", v & 32'h0007_0000, 32'h0);
        wr(5'h08, 32'h0);
        rd(5'h0C); chk("R8 stays clear after release", v & 32'h0007_0000, 32'h0);
        @(negedge clk); rx_frm_err = 1'b1; @(negedge clk); rx_frm_err = 1'b0;
        rd(5'h0C); chk("R7 framing", v & 32'h0007_0000, 32'h0002_0000);
        @(negedge clk); rx_par_err = 1'b1; @(negedge clk); rx_par_err = 1'b0;
        rd(5'h0C); chk("R7 parity", v & 32'h0007_0000, 32'h0003_0000);

        // R12 busy separate from empty
        tx_busy = 1'b1;
        rd(5'h0C); chk("R12 busy and empty", v & 32'h0240_0000, 32'h0240_0000);
        tx_busy = 1'b0;
        rd(5'h0C); chk("R12 idle", v & 32'h0240_0000, 32'h0040_0000);

        // R13 / R5 / R6 receive path
        push(8'h77);
        rd(5'h0C); chk("R13 push dropped while disabled", v & 32'h0010_0000, 32'h0010_0000);
        wr(5'h08, 32'h0000_2000);
        push(8'hA1); push(8'h5C);
        rd(5'h0C); chk("R5 not empty", v & 32'h0010_0000, 32'h0);
        rd(5'h04); chk("R5 first", v, 32'hA1);
        rd(5'h04); chk("R5 second", v, 32'h5C);
        rd(5'h04); chk("R6 empty read", v, 32'h0);
        rd(5'h04); chk("R6 empty read again", v, 32'h0);
        push(8'h3E);
        rd(5'h04); chk("R6 pointer held", v, 32'h3E);

        // R9 held queue resets
        push(8'h01); push(8'h02);
        wr(5'h08, 32'h0080_2000);
        rd(5'h0C); chk("R9 rx emptied", v & 32'h0010_0000, 32'h0010_0000);
        push(8'h44);
        rd(5'h0C); chk("R9 rx kept empty", v & 32'h0010_0000, 32'h0010_0000);
        wr(5'h08, 32'h0000_2000);
        rd(5'h04); chk("R9 rx nothing after release", v, 32'h0);
        wr(5'h08, 32'h0040_0000);
        wr(5'h00, 32'h55);
        rd(5'h0C); chk("R9 tx kept empty", v & 32'h0040_0000, 32'h0040_0000);
        wr(5'h08, 32'h0);

        // R10 receive threshold
        wr(5'h10, 32'h0000_0002);
        wr(5'h08, 32'h0800_2000);
        chk("R10 empty below", {31'h0, irq}, 32'h0);
        push(8'h10);
        chk("R10 one below", {31'h0, irq}, 32'h0);
        push(8'h20);
        chk("R10 at threshold", {31'h0, irq}, 32'h1);
        rd(5'h04);
        chk("R10 back below", {31'h0, irq}, 32'h0);
        rd(5'h04);

        // R11 transmit threshold
        wr(5'h10, 32'h0000_0100);
        wr(5'h08, 32'h1000_0000);
        chk("R11 empty", {31'h0, irq}, 32'h1);
        wr(5'h00, 32'hA0);
        chk("R11 at threshold", {31'h0, irq}, 32'h1);
        wr(5'h00, 32'hA1);
        chk("R11 above threshold", {31'h0, irq}, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule